// File: doc/BRIEF.md
# Dual-Seed CRC16 Generator and Checker

This block computes a 16-bit cyclic redundancy check over a stream of payload bytes. It serves both directions of a packet link. In transmit mode it takes the payload bytes and then emits the two check bytes that go after them on an output byte stream. The check value starts from either a programmed seed or from zero, chosen per packet. In receive mode it takes the payload and then the two received check bytes. It runs two CRC registers side by side, one started from the programmed seed and one started from zero. When the packet ends it reports which of the two starting values reproduces the received check field.

Bytes enter through a valid/ready stream. A byte is taken on every rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on internal state and never on `in_valid`. It goes low while the block is sending check bytes, so the upstream stalls during that time. The outgoing check bytes use a second valid/ready stream. Once `out_valid` rises, it stays high and `out_data` stays unchanged until `out_ready` is seen high at a rising edge. The direction (`rx_mode`), the seed choice (`tx_seed_sel`) and the seed value (`crc_seed`) are read only on the start byte of a packet. The framing logic around the block decides which bytes are payload. The length byte is not part of the payload.

Top module: `crc16_dual`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `out_valid`, `chk_valid`, `seed_match`, `zero_match` and `crc_ok` are all 0.
- R2: The CRC generator polynomial is x^16 + x^15 + x^2 + 1 (0x8005). Each byte is folded in most significant bit first. There is no bit reflection and no final inversion. For example, the byte 0x80 folded from a zero start gives 0x8303.
- R3: In transmit mode the two output bytes are the CRC of the payload. The CRC starts from `crc_seed` when `tx_seed_sel` = 1 and from 0 when `tx_seed_sel` = 0. The seed value and the select bit are taken from the cycle in which the start byte is accepted, and later changes to them have no effect on that packet.
- R4: After the last payload byte is accepted in transmit mode, `out_valid` is high on the next cycle with the high CRC byte, followed by the low CRC byte. `in_ready` is 0 while `out_valid` is 1. A byte that is stalled by `out_ready` = 0 holds its value. `out_valid` drops after the low byte is accepted.
- R5: In receive mode the two bytes accepted after the last payload byte are the received CRC, high byte first. `chk_valid` pulses for exactly one cycle, in the cycle after the low byte is accepted. `seed_match` is 1 if the received value equals the CRC started from the seed, and `zero_match` is 1 if it equals the CRC started from zero.
- R6: `crc_ok` is the OR of `seed_match` and `zero_match`. All three hold their values until the next `chk_valid` pulse.
- R7: A byte accepted with `in_start` = 1 reloads both CRC registers, even in the middle of a packet. A byte can carry `in_start` and `in_last` together, forming a one-byte packet. A new packet can start in the cycle right after the previous packet finishes, with no idle cycle.
- R8: `rx_mode` is read on the start byte (0 = transmit, 1 = receive). Changing it during the rest of the packet has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| crc_seed | input | 16 | Programmed CRC start value |
| tx_seed_sel | input | 1 | Transmit start value: 1 = seed, 0 = zero |
| rx_mode | input | 1 | Packet direction: 0 = transmit, 1 = receive |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input byte |
| in_start | input | 1 | Byte is the first payload byte of a packet |
| in_last | input | 1 | Byte is the last payload byte of a packet |
| out_valid | output | 1 | Output CRC byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output CRC byte, high byte first |
| chk_valid | output | 1 | One-cycle pulse: receive check result is fresh |
| seed_match | output | 1 | Received CRC matches the seed-started CRC |
| zero_match | output | 1 | Received CRC matches the zero-started CRC |
| crc_ok | output | 1 | Either match flag is set |

## Verification
The bench builds the block with its default parameters: a 16-bit CRC, the 0x8005 polynomial and 8-bit bytes. This keeps every value the bench computes comparable with the fixed byte order and the known single-byte value 0x8303. With these parameters a random seed of zero makes both match flags true at once. Random payload lengths of 1 to 20 bytes, random gaps in input and output, and control inputs that change after the start byte reach the stall, reload, back-to-back and latched-mode cases.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;

  typedef enum logic [2:0] {
    ST_PAY   = 3'd0,
    ST_TX_HI = 3'd1,
    ST_TX_LO = 3'd2,
    ST_RX_HI = 3'd3,
    ST_RX_LO = 3'd4
  } ctl_state_e;
endpackage

// File: rtl/crc16_lane.sv
module crc16_lane #(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8,
  parameter logic [CW-1:0] POLY = 16'h8005
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          load,
  input  logic [CW-1:0] init,
  input  logic [DW-1:0] data,
  output logic [CW-1:0] crc
);
  function automatic logic [CW-1:0] fold(input logic [CW-1:0] c_in, input logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic fb;
    c = c_in;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = c[CW-1] ^ d[i];
      c  = {c[CW-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  logic [CW-1:0] base;
  assign base = load ? init : crc;

  always_ff @(posedge clk) begin
    if (rst) crc <= '0;
    else if (step) crc <= fold(base, data);
  end
endmodule

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_start,
  input  logic in_last,
  input  logic rx_mode,
  input  logic tx_seed_sel,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic out_hi,
  output logic pay_step,
  output logic pay_load,
  output logic cap_hi,
  output logic cmp_en,
  output logic use_seed
);
  ctl_state_e state_q, state_d;
  logic mode_q, sel_q;
  logic acc, mode_eff;

  assign in_ready  = (state_q == ST_PAY) || (state_q == ST_RX_HI) || (state_q == ST_RX_LO);
  assign out_valid = (state_q == ST_TX_HI) || (state_q == ST_TX_LO);
  assign out_hi    = (state_q == ST_TX_HI);
  assign acc       = in_valid && in_ready;
  assign pay_step  = acc && (state_q == ST_PAY);
  assign pay_load  = pay_step && in_start;
  assign cap_hi    = acc && (state_q == ST_RX_HI);
  assign cmp_en    = acc && (state_q == ST_RX_LO);
  assign mode_eff  = in_start ? rx_mode : mode_q;
  assign use_seed  = sel_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PAY:   if (pay_step && in_last) state_d = mode_eff ? ST_RX_HI : ST_TX_HI;
      ST_TX_HI: if (out_ready) state_d = ST_TX_LO;
      ST_TX_LO: if (out_ready) state_d = ST_PAY;
      ST_RX_HI: if (acc) state_d = ST_RX_LO;
      ST_RX_LO: if (acc) state_d = ST_PAY;
      default:  state_d = ST_PAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_PAY;
      mode_q  <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pay_load) begin
        mode_q <= rx_mode;
        sel_q  <= tx_seed_sel;
      end
    end
  end

  // R4
  tx_start_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_last));
endmodule

// File: rtl/crc16_cmp.sv
module crc16_cmp #(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_hi,
  input  logic          cmp_en,
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] crc_seeded,
  input  logic [CW-1:0] crc_zeroed,
  output logic          chk_valid,
  output logic          seed_match,
  output logic          zero_match
);
  logic [DW-1:0] hi_q;
  logic [CW-1:0] rx_word;

  assign rx_word = {hi_q, data};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q       <= '0;
      chk_valid  <= 1'b0;
      seed_match <= 1'b0;
      zero_match <= 1'b0;
    end else begin
      chk_valid <= cmp_en;
      if (cap_hi) hi_q <= data;
      if (cmp_en) begin
        seed_match <= (rx_word == crc_seeded);
        zero_match <= (rx_word == crc_zeroed);
      end
    end
  end

  // R5
  chk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> !chk_valid);

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |-> ($stable(seed_match) && $stable(zero_match)));
endmodule

// File: rtl/crc16_dual.sv
module crc16_dual
  import crc16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CRC_W-1:0]  crc_seed,
  input  logic              tx_seed_sel,
  input  logic              rx_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_start,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              chk_valid,
  output logic              seed_match,
  output logic              zero_match,
  output logic              crc_ok
);
  localparam int unsigned NLANE = 2;

  logic pay_step, pay_load, cap_hi, cmp_en, use_seed, out_hi;
  logic [CRC_W-1:0] lane_crc [NLANE];
  logic [CRC_W-1:0] tx_crc;

  crc16_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .rx_mode(rx_mode), .tx_seed_sel(tx_seed_sel),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .out_hi(out_hi), .pay_step(pay_step), .pay_load(pay_load),
    .cap_hi(cap_hi), .cmp_en(cmp_en), .use_seed(use_seed)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [CRC_W-1:0] init_val;
    if (g == 0) begin : g_seeded
      assign init_val = crc_seed;
    end else begin : g_zeroed
      assign init_val = '0;
    end
    crc16_lane #(.CW(CRC_W), .DW(BYTE_W), .POLY(CRC_POLY)) u_lane (
      .clk(clk), .rst(rst), .step(pay_step), .load(pay_load),
      .init(init_val), .data(in_data), .crc(lane_crc[g])
    );
  end

  assign tx_crc   = use_seed ? lane_crc[0] : lane_crc[1];
  assign out_data = out_hi ? tx_crc[CRC_W-1 -: BYTE_W] : tx_crc[BYTE_W-1:0];

  crc16_cmp #(.CW(CRC_W), .DW(BYTE_W)) u_cmp (
    .clk(clk), .rst(rst), .cap_hi(cap_hi), .cmp_en(cmp_en), .data(in_data),
    .crc_seeded(lane_crc[0]), .crc_zeroed(lane_crc[1]),
    .chk_valid(chk_valid), .seed_match(seed_match), .zero_match(zero_match)
  );

  assign crc_ok = seed_match | zero_match;

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  chk_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> $past(in_valid && in_ready));
endmodule

// File: tb/crc16_dual_test.sv
module crc16_dual_test;
  localparam time CLK_PERIOD = 10ns;

  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] crc_seed = '0;
  logic tx_seed_sel = 1'b0, rx_mode = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, chk_valid, seed_match, zero_match, crc_ok;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0;
  bit allow_idle = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_dual uut (
    .clk(clk), .rst(rst), .crc_seed(crc_seed), .tx_seed_sel(tx_seed_sel),
    .rx_mode(rx_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_start(in_start), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .chk_valid(chk_valid), .seed_match(seed_match), .zero_match(zero_match),
    .crc_ok(crc_ok)
  );

  function automatic logic [15:0] crc_ref(input logic [15:0] init, input bq_t b);
    logic [15:0] c = init;
    foreach (b[k]) begin
      for (int i = 7; i >= 0; i--) begin
        logic fb = c[15] ^ b[k][i];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h8005;
      end
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic push(input logic [7:0] b, input bit s, input bit l);
    bit rdy;
    if (allow_idle && ($urandom % 4 == 0)) begin
      in_valid = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    in_data = b; in_start = s; in_last = l; in_valid = 1'b1;
    do begin
      rdy = in_ready;
      @(posedge clk); @(negedge clk);
    end while (!rdy);
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
  endtask

  task automatic scramble_ctl();
    crc_seed = 16'($urandom);
    tx_seed_sel = 1'($urandom);
    rx_mode = 1'($urandom);
  endtask

  // transmit one packet and return the two bytes emitted
  task automatic run_tx(input logic [15:0] seed, input bit sel, input bq_t q, output logic [15:0] got);
    logic [7:0] rec[2];
    int n = 0;
    crc_seed = seed; tx_seed_sel = sel; rx_mode = 1'b0;
    foreach (q[i]) begin
      push(q[i], i == 0, i == q.size() - 1);
      if (i == 0) scramble_ctl();  // R3 R8: changes after the start byte must not matter
    end
    check(out_valid === 1'b1, "R4 out_valid after last", {31'b0, out_valid}, 32'd1);
    while (n < 2) begin
      logic v, r;
      logic [7:0] d;
      out_ready = allow_idle ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (out_valid) check(in_ready === 1'b0, "R4 in_ready low while sending", {31'b0, in_ready}, 32'd0);
      v = out_valid; r = out_ready; d = out_data;
      @(posedge clk); @(negedge clk);
      if (v && r) begin
        rec[n] = d; n++;
      end else if (v) begin
        check(out_valid === 1'b1 && out_data === d, "R4 stalled byte held", {24'b0, out_data}, {24'b0, d});
      end
    end
    out_ready = 1'b0;
    check(out_valid === 1'b0, "R4 out_valid drops", {31'b0, out_valid}, 32'd0);
    got = {rec[0], rec[1]};
  endtask

  task automatic run_rx(input logic [15:0] seed, input bq_t q, input int kind);
    logic [15:0] cs, cz, recv;
    bit es, ez;
    cs = crc_ref(seed, q);
    cz = crc_ref(16'h0, q);
    case (kind)
      0: recv = cs;
      1: recv = cz;
      default: recv = cs ^ (16'h1 << ($urandom % 16));
    endcase
    es = (recv == cs); ez = (recv == cz);
    crc_seed = seed; rx_mode = 1'b1; tx_seed_sel = 1'($urandom);
    foreach (q[i]) begin
      push(q[i], i == 0, i == q.size() - 1);
      if (i == 0) scramble_ctl();  // R8: mode is latched on the start byte
    end
    push(recv[15:8], 1'b0, 1'b0);
    push(recv[7:0], 1'b0, 1'b0);
    check(chk_valid === 1'b1, "R5 chk_valid pulse", {31'b0, chk_valid}, 32'd1);
    check(seed_match === es, "R5 seed_match", {31'b0, seed_match}, {31'b0, es});
    check(zero_match === ez, "R5 zero_match", {31'b0, zero_match}, {31'b0, ez});
    check(crc_ok === (es | ez), "R6 crc_ok", {31'b0, crc_ok}, {31'b0, es | ez});
    if (!allow_idle) return;
    @(posedge clk); @(negedge clk);
    check(chk_valid === 1'b0, "R5 chk_valid one cycle", {31'b0, chk_valid}, 32'd0);
    check(seed_match === es && zero_match === ez && crc_ok === (es | ez), "R6 flags held",
          {29'b0, seed_match, zero_match, crc_ok}, {29'b0, es, ez, es | ez});
  endtask

  function automatic bq_t rand_pkt(input int len);
    bq_t q;
    for (int i = 0; i < len; i++) q.push_back(8'($urandom));
    return q;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [15:0] got, s;
    bq_t q;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1
    check(in_ready === 1'b1, "R1 in_ready", {31'b0, in_ready}, 32'd1);
    check({out_valid, chk_valid, seed_match, zero_match, crc_ok} === 5'b0, "R1 outputs idle",
          {27'b0, out_valid, chk_valid, seed_match, zero_match, crc_ok}, 32'd0);

    // R2 known value, one-byte packet (R7)
    q = '{8'h80};
    run_tx(16'hABCD, 1'b0, q, got);
    check(got === 16'h8303, "R2 R7 single byte 0x80 zero start", {16'b0, got}, 32'h8303);

    // R3 seed start
    q = '{8'h12, 8'h34, 8'h56};
    run_tx(16'hFFFF, 1'b1, q, got);
    check(got === crc_ref(16'hFFFF, q), "R3 seed start", {16'b0, got}, {16'b0, crc_ref(16'hFFFF, q)});

    // R7 start in the middle of a packet reloads
    crc_seed = 16'h1111; tx_seed_sel = 1'b1; rx_mode = 1'b0;
    push(8'hAA, 1'b1, 1'b0);
    push(8'hBB, 1'b0, 1'b0);
    q = '{8'hC3, 8'h5A};
    run_tx(16'h2222, 1'b1, q, got);
    check(got === crc_ref(16'h2222, q), "R7 mid-packet reload", {16'b0, got}, {16'b0, crc_ref(16'h2222, q)});

    // R7 back-to-back with no idle cycles, R5 zero-seed match
    allow_idle = 1'b0;
    q = '{8'h01, 8'h02, 8'h03};
    run_rx(16'h7777, q, 1);
    q = '{8'hFE};
    run_rx(16'h0BAD, q, 0);
    run_tx(16'h4321, 1'b1, q, got);
    check(got === crc_ref(16'h4321, q), "R7 back-to-back tx", {16'b0, got}, {16'b0, crc_ref(16'h4321, q)});
    allow_idle = 1'b1;

    // R5 R6 both flags with zero seed, and corrupted field
    q = '{8'h10, 8'h20};
    run_rx(16'h0000, q, 0);
    run_rx(16'h5555, q, 2);

    // random mix
    for (int p = 0; p < 60; p++) begin
      q = rand_pkt(1 + ($urandom % 20));
      s = (p % 10 == 3) ? 16'h0 : 16'($urandom);
      if ($urandom % 2) begin
        bit sel = 1'($urandom);
        run_tx(s, sel, q, got);
        check(got === crc_ref(sel ? s : 16'h0, q), "R2 R3 random tx",
              {16'b0, got}, {16'b0, crc_ref(sel ? s : 16'h0, q)});
      end else begin
        run_rx(s, q, int'($urandom % 3));
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule